// File: doc/BRIEF.md
# Pulse Edge Counter with Cycle Timestamp

This block counts transitions on one asynchronous digital pulse line, such as the output of a flow meter, and runs alongside it a cycle counter that advances on every clock. Whenever an edge is counted, the current cycle count is stored as the timestamp of the latest edge. Neither counter can be started, stopped or paused: both begin at reset and run until the next reset.

A host reads the edge count and the latest-edge timestamp together as one coherent pair. It works out the interval between events from the difference of two timestamps, with one cycle being 25 ns at the intended 40 MHz clock. The pulse rate is the count difference divided by that interval. A separate sample strobe, driven by some other periodic acquisition, copies the edge count into a snapshot register, so the count can be subsampled at that acquisition's rate. All rate arithmetic is done by the host.

Top module: `pulse_stamp_counter`

## Requirements
- R1: While reset is high and on the first cycle after it, `rd_count`, `rd_stamp`, `snap_count` and `rd_valid` are all zero.
- R2: The level present on `pulse_in` when reset is released is never counted as an edge, even if it is high. The first edge counted is the first change after the synchronizer has filled.
- R3: With `both_edges` = 0, only a 0-to-1 change of `pulse_in` is counted. A 1-to-0 change leaves both the count and the timestamp unchanged.
- R4: With `both_edges` = 1, every change of `pulse_in` in either direction adds one to the edge count.
- R5: The cycle counter is 0 during the first cycle after reset and rises by one every clock. A change of `pulse_in` that is set up before rising clock edge j, where edge 0 is the first edge with reset low, is counted at edge j+2. The timestamp stored is j+2.
- R6: Between counted edges, the stored timestamp and the edge count do not change, however many cycles pass.
- R7: A one-cycle `rd_req` at edge k loads `rd_count` and `rd_stamp` with the count and timestamp held just before edge k. `rd_valid` is high only during the cycle after each request.
- R8: If an edge is counted at the same clock edge as a read request, the read returns the pair from before that edge. The next read returns the updated pair.
- R9: A `sample_strobe` at edge k loads `snap_count` with the count held just before edge k. Without a strobe, `snap_count` holds its value.
- R10: The edge count wraps modulo 2^CNT_W and the timestamp wraps modulo 2^TS_W. The unsigned difference of two stamps less than one wrap apart, taken modulo 2^TS_W, equals the elapsed cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one domain |
| rst | input | 1 | Synchronous reset, active high |
| pulse_in | input | 1 | Asynchronous pulse line to be counted |
| both_edges | input | 1 | 0: count rising changes only; 1: count every change |
| sample_strobe | input | 1 | Copies the edge count into the snapshot register |
| rd_req | input | 1 | One-cycle request to capture the count/timestamp pair |
| rd_count | output | CNT_W | Edge count captured by the last read request |
| rd_stamp | output | TS_W | Latest-edge timestamp captured by the last read request |
| rd_valid | output | 1 | High during the cycle after a read request |
| snap_count | output | CNT_W | Edge count captured by the last sample strobe |

## Verification
The bench builds the block with an 8-bit edge counter and a 12-bit cycle counter instead of the 32-bit defaults. At these widths, a run of 260 toggles wraps the edge count, and a few thousand idle cycles carry the timestamp past its wrap. This lets the bench check modular stamp subtraction across the wrap boundary within a short run. The narrow widths do not change the synchronizer depth or any latency, so the edge-to-stamp timing and the read-collision ordering are exercised exactly as at full width.

// File: rtl/pulse_stamp_counter.sv
module pulse_stamp_counter #(
  parameter int CNT_W = 32,
  parameter int TS_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pulse_in,
  input  logic             both_edges,
  input  logic             sample_strobe,
  input  logic             rd_req,
  output logic [CNT_W-1:0] rd_count,
  output logic [TS_W-1:0]  rd_stamp,
  output logic             rd_valid,
  output logic [CNT_W-1:0] snap_count
);

  localparam int FILL_W = 3;

  logic              s1, s2, prev;
  logic [FILL_W-1:0] fill;
  logic [TS_W-1:0]   cyc;
  logic [TS_W-1:0]   last_ts;
  logic [CNT_W-1:0]  edge_cnt;
  logic              hit;

  assign hit = fill[FILL_W-1] & (both_edges ? (s2 ^ prev) : (s2 & ~prev));

  always_ff @(posedge clk) begin
    if (rst) begin
      s1   <= 1'b0;
      s2   <= 1'b0;
      prev <= 1'b0;
      fill <= '0;
    end else begin
      s1   <= pulse_in;
      s2   <= s1;
      prev <= s2;
      fill <= {fill[FILL_W-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc      <= '0;
      edge_cnt <= '0;
      last_ts  <= '0;
    end else begin
      cyc <= cyc + {{(TS_W-1){1'b0}}, 1'b1};
      if (hit) begin
        edge_cnt <= edge_cnt + {{(CNT_W-1){1'b0}}, 1'b1};
        last_ts  <= cyc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_count   <= '0;
      rd_stamp   <= '0;
      rd_valid   <= 1'b0;
      snap_count <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) begin
        rd_count <= edge_cnt;
        rd_stamp <= last_ts;
      end
      if (sample_strobe)
        snap_count <= edge_cnt;
    end
  end

  assert_cycle_step_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cyc == $past(cyc) + {{(TS_W-1){1'b0}}, 1'b1});

  assert_quiet_until_filled_R2: assert property (@(posedge clk) disable iff (rst)
    !fill[FILL_W-1] |=> $stable(edge_cnt));

  assert_count_steps_by_one_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (edge_cnt == $past(edge_cnt)) ||
             (edge_cnt == $past(edge_cnt) + {{(CNT_W-1){1'b0}}, 1'b1}));

  assert_stamp_holds_R6: assert property (@(posedge clk) disable iff (rst)
    $stable(edge_cnt) |-> $stable(last_ts));

  assert_valid_follows_req_R7: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid);

  assert_valid_only_after_req_R7: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rd_valid);

  assert_read_pre_update_R8: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_count == $past(edge_cnt) && rd_stamp == $past(last_ts));

  assert_snap_holds_R9: assert property (@(posedge clk) disable iff (rst)
    !sample_strobe |=> $stable(snap_count));

endmodule

// File: tb/pulse_stamp_counter_tb.sv
module pulse_stamp_counter_tb;
  localparam int CW = 8;
  localparam int TW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pulse_in = 1'b0;
  logic          both_edges = 1'b0;
  logic          sample_strobe = 1'b0;
  logic          rd_req = 1'b0;
  logic [CW-1:0] rd_count;
  logic [TW-1:0] rd_stamp;
  logic          rd_valid;
  logic [CW-1:0] snap_count;

  int errors = 0;
  int checks = 0;
  int ncyc = 0;
  int wd = 0;
  bit done = 0;

  int exp_cnt = 0;
  int exp_ts = 0;

  pulse_stamp_counter #(.CNT_W(CW), .TS_W(TW)) u_dut (
    .clk(clk), .rst(rst), .pulse_in(pulse_in), .both_edges(both_edges),
    .sample_strobe(sample_strobe), .rd_req(rd_req), .rd_count(rd_count),
    .rd_stamp(rd_stamp), .rd_valid(rd_valid), .snap_count(snap_count));

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!rst) ncyc <= ncyc + 1;
    wd <= wd + 1;
    if (wd > 150000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pulse(input logic v, output int stamp);
    stamp = (ncyc + 2) % (1 << TW);
    pulse_in = v;
    tick(3);
  endtask

  task automatic do_read(input string req, input int ecnt, input int ets);
    rd_req = 1'b1;
    tick(1);
    rd_req = 1'b0;
    chk(rd_valid == 1'b1, req, int'(rd_valid), 1);
    chk(rd_count == CW'(ecnt), req, int'(rd_count), ecnt % (1 << CW));
    chk(rd_stamp == TW'(ets), req, int'(rd_stamp), ets % (1 << TW));
    tick(1);
  endtask

  task automatic test_reset_R1_R2();
    pulse_in = 1'b1;
    rst = 1'b1;
    tick(3);
    chk(rd_count == 0 && rd_stamp == 0 && snap_count == 0, "R1", int'(rd_count), 0);
    chk(rd_valid == 1'b0, "R1", int'(rd_valid), 0);
    rst = 1'b0;
    tick(1);
    chk(rd_count == 0 && rd_valid == 0 && snap_count == 0, "R1", int'(rd_count), 0);
    tick(10);
    do_read("R2", 0, 0);
    both_edges = 1'b1;
    both_edges = 1'b0;
  endtask

  task automatic test_rising_R3_R5();
    int st;
    both_edges = 1'b0;
    set_pulse(1'b0, st);
    do_read("R3", exp_cnt, exp_ts);
    set_pulse(1'b1, st);
    exp_cnt++; exp_ts = st;
    do_read("R5", exp_cnt, exp_ts);
    set_pulse(1'b0, st);
    do_read("R3", exp_cnt, exp_ts);
  endtask

  task automatic test_both_R4();
    int st;
    both_edges = 1'b1;
    set_pulse(1'b1, st);
    exp_cnt++; exp_ts = st;
    set_pulse(1'b0, st);
    exp_cnt++; exp_ts = st;
    do_read("R4", exp_cnt, exp_ts);
    both_edges = 1'b0;
  endtask

  task automatic test_hold_R6();
    tick(50);
    do_read("R6", exp_cnt, exp_ts);
    tick(7);
    do_read("R6", exp_cnt, exp_ts);
  endtask

  task automatic test_interval_R5();
    int s1, s2;
    both_edges = 1'b0;
    set_pulse(1'b1, s1);
    exp_cnt++;
    tick(34);
    set_pulse(1'b0, s2);
    set_pulse(1'b1, s2);
    exp_cnt++; exp_ts = s2;
    chk(((s2 - s1) % (1 << TW)) == 40, "R5", (s2 - s1), 40);
    do_read("R5", exp_cnt, exp_ts);
    set_pulse(1'b0, s2);
  endtask

  task automatic test_valid_R7();
    tick(1);
    chk(rd_valid == 1'b0, "R7", int'(rd_valid), 0);
    rd_req = 1'b1;
    tick(1);
    rd_req = 1'b0;
    chk(rd_valid == 1'b1, "R7", int'(rd_valid), 1);
    tick(1);
    chk(rd_valid == 1'b0, "R7", int'(rd_valid), 0);
  endtask

  task automatic test_collide_R8();
    int st;
    both_edges = 1'b0;
    st = (ncyc + 2) % (1 << TW);
    pulse_in = 1'b1;
    tick(2);
    rd_req = 1'b1;
    tick(1);
    rd_req = 1'b0;
    chk(rd_count == CW'(exp_cnt), "R8", int'(rd_count), exp_cnt % (1 << CW));
    chk(rd_stamp == TW'(exp_ts), "R8", int'(rd_stamp), exp_ts);
    exp_cnt++; exp_ts = st;
    tick(1);
    do_read("R8", exp_cnt, exp_ts);
    set_pulse(1'b0, st);
  endtask

  task automatic test_snap_R9();
    int st;
    sample_strobe = 1'b1;
    tick(1);
    sample_strobe = 1'b0;
    chk(snap_count == CW'(exp_cnt), "R9", int'(snap_count), exp_cnt % (1 << CW));
    set_pulse(1'b1, st);
    exp_cnt++; exp_ts = st;
    set_pulse(1'b0, st);
    chk(snap_count == CW'(exp_cnt - 1), "R9", int'(snap_count), (exp_cnt - 1) % (1 << CW));
    sample_strobe = 1'b1;
    tick(1);
    sample_strobe = 1'b0;
    chk(snap_count == CW'(exp_cnt), "R9", int'(snap_count), exp_cnt % (1 << CW));
  endtask

  task automatic test_wrap_R10();
    int last, s_old, s_new, t_old, t_new;
    both_edges = 1'b1;
    for (int i = 0; i < 260; i++) begin
      last = (ncyc + 2) % (1 << TW);
      pulse_in = ~pulse_in;
      tick(1);
    end
    tick(3);
    exp_cnt += 260; exp_ts = last;
    do_read("R10", exp_cnt, exp_ts);
    s_old = last; t_old = ncyc;
    while (ncyc < 4200) tick(1);
    tick(123);
    set_pulse(~pulse_in, s_new);
    t_new = ncyc - 3;
    exp_cnt++; exp_ts = s_new;
    do_read("R10", exp_cnt, exp_ts);
    chk(((int'(rd_stamp) - s_old) & ((1 << TW) - 1)) == ((s_new - s_old) & ((1 << TW) - 1)),
        "R10", int'(rd_stamp), s_new);
    chk(ncyc > (1 << TW), "R10", ncyc, 1 << TW);
    both_edges = 1'b0;
  endtask

  initial begin
    test_reset_R1_R2();
    test_rising_R3_R5();
    test_both_R4();
    test_hold_R6();
    test_interval_R5();
    test_valid_R7();
    test_collide_R8();
    test_snap_R9();
    test_wrap_R10();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule